// File: doc/BRIEF.md
# Jumping Binary Sequence Counter

This block is a 4-bit synchronous counter with a fixed count cycle that is not plain binary. It counts up by one on each enabled rising clock edge. At two points it jumps instead. From 6 it goes straight to 10, so 7, 8 and 9 are skipped. From 12 it goes back to 1.

Reset clears the count to 0. The value 0 therefore appears only once, directly after reset. From then on the counter runs a nine-state loop: 1, 2, 3, 4, 5, 6, 10, 11, 12, and back to 1.

Both jumps are decided in the next-state logic, and every bit of the count register is loaded on the same edge. As a result, the codes that would trigger a jump in a ripple design (7 and 13) never reach the output, not even as a glitch. A one-cycle pulse reports each jump. An enable input freezes the counter.

Top module: `jump_seq_counter`

## Requirements
- R1: While `rst_ni` is low, `count_o` is 0000 and `jump_o` is 0. Reset acts at once, without waiting for a clock edge.
- R2: On a rising edge with `en_i` high, a count of 0, 1, 2, 3, 4, 5, 10 or 11 advances by exactly one.
- R3: On an enabled edge, a count of 6 (0110) becomes 10 (1010).
- R4: On an enabled edge, a count of 12 (1100) becomes 1 (0001).
- R5: After the first enabled edge following reset, the count repeats the nine-state loop 1,2,3,4,5,6,10,11,12 and never shows 0.
- R6: `count_o` never shows 7, 8, 9, 13, 14 or 15. This includes 7 (0111) and 13 (1101).
- R7: `jump_o` is high for exactly the one cycle after an edge that moved the count 6→10 or 12→1, and low in every other cycle.
- R8: On a rising edge with `en_i` low, the count holds its value and `jump_o` goes low.
- R9: Reset asserted in the middle of the loop returns the count to 0000, and counting then restarts from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable, synchronous; holds the count when low |
| count_o | output | 4 | Current count, bit 3 is the MSB |
| jump_o | output | 1 | High for one cycle after a 6→10 or 12→1 step |

## Verification
If the next-state logic is wrong, `count_o` shows a wrong value one clock edge after the faulty decision. A missed jump shows up at once as a forbidden code (7 or 13) on the output. A wrong jump target shows up as a broken loop on the very next edge, and the bench compares every step against its own model of the loop.

A jump flag stuck high or stuck low is seen in `jump_o` in the cycle after the step it should mark. A faulty enable path shows up as the count moving or the flag staying high during a hold.

// File: rtl/jump_cnt_pkg.sv
package jump_cnt_pkg;
  localparam int CNT_W = 4;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    cnt_t code;
    logic jump;
  } step_t;
endpackage

// File: rtl/jc_next.sv
module jc_next
  import jump_cnt_pkg::*;
#(
  parameter int SKIP_FROM = 7,
  parameter int SKIP_TO   = 10,
  parameter int WRAP_FROM = 13,
  parameter int WRAP_TO   = 1
) (
  input  cnt_t  cur_i,
  input  logic  en_i,
  output step_t nxt_o
);
  localparam cnt_t SkipFrom = cnt_t'(SKIP_FROM);
  localparam cnt_t SkipTo   = cnt_t'(SKIP_TO);
  localparam cnt_t WrapFrom = cnt_t'(WRAP_FROM);
  localparam cnt_t WrapTo   = cnt_t'(WRAP_TO);

  cnt_t inc;
  logic illegal;

  assign inc     = cur_i + cnt_t'(1);
  // codes inside the skipped window or at/after the wrap trigger
  assign illegal = ((cur_i >= SkipFrom) && (cur_i < SkipTo)) || (cur_i >= WrapFrom);

  always_comb begin
    nxt_o = '{code: cur_i, jump: 1'b0};
    if (en_i) begin
      if (illegal)               nxt_o = '{code: WrapTo, jump: 1'b0};
      else if (inc == SkipFrom)  nxt_o = '{code: SkipTo, jump: 1'b1};
      else if (inc == WrapFrom)  nxt_o = '{code: WrapTo, jump: 1'b1};
      else                       nxt_o = '{code: inc,    jump: 1'b0};
    end
  end
endmodule

// File: rtl/jc_reg.sv
module jc_reg #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/jump_seq_counter.sv
module jump_seq_counter
  import jump_cnt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [CNT_W-1:0] count_o,
  output logic             jump_o
);
  localparam int SkipFrom = 7;
  localparam int SkipTo   = 10;
  localparam int WrapFrom = 13;
  localparam int WrapTo   = 1;

  step_t nxt;
  cnt_t  count_q;
  logic  jump_q;

  jc_next #(
    .SKIP_FROM(SkipFrom), .SKIP_TO(SkipTo),
    .WRAP_FROM(WrapFrom), .WRAP_TO(WrapTo)
  ) u_next (
    .cur_i(count_q),
    .en_i (en_i),
    .nxt_o(nxt)
  );

  jc_reg #(.W(CNT_W)) u_cnt_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (nxt.code),
    .q_o   (count_q)
  );

  jc_reg #(.W(1)) u_jump_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (nxt.jump),
    .q_o   (jump_q)
  );

  assign count_o = count_q;
  assign jump_o  = jump_q;

  // R6
  no_trigger_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q != cnt_t'(SkipFrom)) && (count_q != cnt_t'(WrapFrom)));
  // R3
  skip_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && count_q == cnt_t'(SkipFrom - 1)) |=> (count_q == cnt_t'(SkipTo) && jump_q));
  // R4
  wrap_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && count_q == cnt_t'(WrapFrom - 1)) |=> (count_q == cnt_t'(WrapTo) && jump_q));
  // R7
  jump_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_q |=> !jump_q);
  // R7
  jump_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_q |-> (count_q == cnt_t'(SkipTo) || count_q == cnt_t'(WrapTo)));
  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(count_q) && !jump_q));
endmodule

// File: tb/sim_jump_seq_counter.sv
module sim_jump_seq_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [3:0] count;
  logic       jump;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  jump_seq_counter u0 (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .en_i   (en),
    .count_o(count),
    .jump_o (jump)
  );

  always #2 clk = ~clk;

  function automatic int model_next(int c);
    if (c == 6)  return 10;
    if (c == 12) return 1;
    return c + 1;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b0;
    #7;
    check("R1 count", count, 0);
    check("R1 jump", jump, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_loop();
    int exp = 0;
    en = 1'b1;
    for (int i = 0; i < 30; i++) begin
      int prev = exp;
      exp = model_next(exp);
      tick();
      check((prev == 6) ? "R3" : (prev == 12) ? "R4" : "R2", count, exp);
      check("R7", jump, (prev == 6 || prev == 12) ? 1 : 0);
      check("R6", (count inside {7, 8, 9, 13, 14, 15}) ? 1 : 0, 0);
      check("R5 no zero", (count == 0) ? 1 : 0, 0);
    end
  endtask

  task automatic t_hold();
    int seen;
    // advance to 10 (jump pending), then freeze
    while (!(count == 6)) tick();
    tick();
    check("R3 at hold", count, 10);
    en = 1'b0;
    seen = count;
    for (int i = 0; i < 4; i++) begin
      tick();
      check("R8 count", count, seen);
      check("R8 jump", jump, 0);
    end
    en = 1'b1;
    tick();
    check("R2 resume", count, 11);
    tick();
    tick();
    check("R4 after hold", count, 1);
    check("R7 after hold", jump, 1);
  endtask

  task automatic t_mid_reset();
    en = 1'b1;
    tick(); tick(); tick();
    #1;
    rst_n = 1'b0;
    #1;
    check("R9 async", count, 0);
    check("R9 jump", jump, 0);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    check("R9 restart", count, 1);
    tick();
    check("R9 restart", count, 2);
  endtask

  initial begin
    t_reset();
    t_loop();
    t_hold();
    t_mid_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule